// File: doc/BRIEF.md
# DisplayPort Lane Enable Controller

This block decides which of four DisplayPort lanes are powered and how the AUX differential pair is routed onto the two sideband pins of the connector. It combines a 2-bit mode select, the cable orientation, a flag that picks between two sources of lane enables, four per-lane software disable bits, and an AUX-to-sideband override field.

Lane enables come from one of two sources. With snooping active, the block watches a strobe interface that reports sink-configuration writes as an address and a data byte. It keeps the last lane count written to address 0x00101 and the last power state written to address 0x00600, and it derives the enabled lanes from those two values. With snooping turned off, each lane follows its own software disable bit. Either result is then masked by the lanes that the current mode allows. The captured snoop values are wiped whenever the upper mode bit drops from 1 to 0.

Top module: `dp_lane_ctl`

## Requirements
- R1: After reset both captured snoop values are zero. With snooping active, all lanes are therefore off until a power state of 1 is captured.
- R2: When mode_sel is 0 (all off) or 1 (USB only), lane_en is 0000 whatever the other inputs are.
- R3: When mode_sel is 3 (USB plus two DP lanes), lane_en[3:2] stay 0. Only lanes 0 and 1 can be enabled. When mode_sel is 2, all four lanes may be enabled.
- R4: A strobe with snp_addr = 0x00101 captures snp_data[4:0] as the lane count, and lane_en shows it from the cycle after that edge. A strobe to any other address leaves both captured values unchanged.
- R5: With snooping active and power state 1, a lane count of 1 enables lane 0, a count of 2 enables lanes 0 and 1, and any other count (4, 0, 3, ...) enables all four lanes, subject to R2 and R3.
- R6: A strobe with snp_addr = 0x00600 captures snp_data[1:0] as the power state. With snooping active, only a power state of 1 lets lanes on. Values 0, 2 and 3 force lane_en to 0000.
- R7: With snoop_off = 1, lane N is enabled exactly when lane_sw_dis[N] is 0, within the lanes the mode allows. With snoop_off = 0, lane_sw_dis has no effect on lane_en.
- R8: A clock edge at which mode_sel[1] is 0 and was 1 at the previous edge clears both captured values. This clear takes priority over a strobe at the same edge. Changes between modes 2 and 3 do not clear them.
- R9: sbu_ctl encodes 00 = open, 01 = straight (AUXP to SBU1, AUXN to SBU2), 10 = crossed (AUXP to SBU2, AUXN to SBU1). When aux_ovr is 1, 2 or 3, sbu_ctl is 01, 10 or 00 respectively, regardless of mode and flip.
- R10: When aux_ovr is 0, sbu_ctl is 00 if mode_sel[1] is 0. Otherwise it is 01 when flip is 0 and 10 when flip is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | USB/DP mode: 0 off, 1 USB, 2 four DP lanes, 3 USB + two DP lanes |
| flip | input | 1 | Cable orientation, 1 = flipped |
| snoop_off | input | 1 | 1 = lanes follow lane_sw_dis, 0 = lanes follow captured snoop values |
| lane_sw_dis | input | 4 | Per-lane software disable, bit N for lane N |
| snp_valid | input | 1 | Strobe: a sink-configuration write is reported this cycle |
| snp_addr | input | 20 | Address of the reported write |
| snp_data | input | 8 | Data of the reported write |
| aux_ovr | input | 2 | AUX/sideband override: 0 automatic, 1 straight, 2 crossed, 3 open |
| lane_en | output | 4 | Lane enables, bit N powers lane N |
| sbu_ctl | output | 2 | Sideband switch: 00 open, 01 straight, 10 crossed |

## Verification
The assertions assume that mode_sel is driven with a defined value in every cycle after reset. They also assume that snp_valid is held low during reset, so nothing is captured before the first clock edge. The fall-clear check additionally assumes that mode_sel[1] does not fall in the first cycle after reset while a strobe is present. The bench changes every input only on the falling clock edge and applies each strobe for exactly one cycle. It keeps snp_valid low during reset and leaves mode_sel at a constant value across the release of reset, so the stimulus stays within these assumptions.

// File: rtl/dp_lane_ctl.sv
module dp_lane_ctl #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5,
  parameter int PWR_W  = 2,
  parameter logic [ADDR_W-1:0] CNT_ADDR = 20'h00101,
  parameter logic [ADDR_W-1:0] PWR_ADDR = 20'h00600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_sel,
  input  logic              flip,
  input  logic              snoop_off,
  input  logic [3:0]        lane_sw_dis,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_data,
  input  logic [1:0]        aux_ovr,
  output logic [3:0]        lane_en,
  output logic [1:0]        sbu_ctl
);

  localparam logic [PWR_W-1:0] PWR_ON = PWR_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [PWR_W-1:0] pwr_q;
  logic             hi_q;
  logic             wipe;
  logic [3:0]       allow, cnt_mask, snoop_mask, path;
  logic             unused_hi;

  assign unused_hi = ^snp_data[DATA_W-1:CNT_W];
  assign wipe      = hi_q & ~mode_sel[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwr_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      hi_q <= mode_sel[1];
      if (wipe) begin
        cnt_q <= '0;
        pwr_q <= '0;
      end else if (snp_valid) begin
        if (snp_addr == CNT_ADDR) cnt_q <= snp_data[CNT_W-1:0];
        if (snp_addr == PWR_ADDR) pwr_q <= snp_data[PWR_W-1:0];
      end
    end
  end

  always_comb begin
    case (cnt_q)
      CNT_W'(1): cnt_mask = 4'b0001;
      CNT_W'(2): cnt_mask = 4'b0011;
      default:   cnt_mask = 4'b1111;
    endcase
    case (mode_sel)
      2'd2:    allow = 4'b1111;
      2'd3:    allow = 4'b0011;
      default: allow = 4'b0000;
    endcase
  end

  assign snoop_mask = (pwr_q == PWR_ON) ? cnt_mask : 4'b0000;
  assign path       = snoop_off ? ~lane_sw_dis : snoop_mask;
  assign lane_en    = allow & path;

  always_comb begin
    case (aux_ovr)
      2'd1:    sbu_ctl = 2'b01;
      2'd2:    sbu_ctl = 2'b10;
      2'd3:    sbu_ctl = 2'b00;
      default: sbu_ctl = mode_sel[1] ? (flip ? 2'b10 : 2'b01) : 2'b00;
    endcase
  end

  // R2
  usb_only_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel[1] |-> lane_en == 4'b0000);

  // R3
  upper_pair_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel == 2'd3 |-> lane_en[3:2] == 2'b00);

  // R6
  power_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!snoop_off && pwr_q != PWR_ON) |-> lane_en == 4'b0000);

  // R8
  fall_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_sel[1]) |=> (cnt_q == '0 && pwr_q == '0));

  // R9
  open_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aux_ovr == 2'd3 |-> sbu_ctl == 2'b00);

  // R10
  sbu_idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_ovr == 2'd0 && !mode_sel[1]) |-> sbu_ctl == 2'b00);

endmodule

// File: tb/tb_dp_lane_ctl.sv
module tb_dp_lane_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode_sel = 2'd2;
  logic        flip = 1'b0;
  logic        snoop_off = 1'b0;
  logic [3:0]  lane_sw_dis = 4'b0000;
  logic        snp_valid = 1'b0;
  logic [19:0] snp_addr = '0;
  logic [7:0]  snp_data = '0;
  logic [1:0]  aux_ovr = 2'd0;
  logic [3:0]  lane_en;
  logic [1:0]  sbu_ctl;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dp_lane_ctl dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .flip(flip),
    .snoop_off(snoop_off), .lane_sw_dis(lane_sw_dis), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .snp_data(snp_data), .aux_ovr(aux_ovr),
    .lane_en(lane_en), .sbu_ctl(sbu_ctl)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic snoop(input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_addr = a; snp_data = d;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 lanes after reset", lane_en, 4'b0000);
    chk("R10 straight sbu after reset", {2'b00, sbu_ctl}, 4'b0001);
  endtask

  task automatic t_power();
    snoop(20'h00101, 8'h04);
    chk("R6 power 0 keeps lanes off", lane_en, 4'b0000);
    snoop(20'h00600, 8'h01);
    chk("R6 power 1 enables", lane_en, 4'b1111);
    snoop(20'h00600, 8'h02);
    chk("R6 power 2 disables", lane_en, 4'b0000);
    snoop(20'h00600, 8'h03);
    chk("R6 power 3 disables", lane_en, 4'b0000);
    snoop(20'h00600, 8'hFD);
    chk("R6 only low two bits used", lane_en, 4'b1111);
  endtask

  task automatic t_count();
    snoop(20'h00101, 8'h01);
    chk("R5 count 1", lane_en, 4'b0001);
    snoop(20'h00101, 8'h02);
    chk("R5 count 2", lane_en, 4'b0011);
    snoop(20'h00101, 8'h03);
    chk("R5 count 3 as four", lane_en, 4'b1111);
    snoop(20'h00101, 8'hE2);
    chk("R4 low five bits captured", lane_en, 4'b0011);
    snoop(20'h00101, 8'h00);
    chk("R5 count 0 as four", lane_en, 4'b1111);
    snoop(20'h00102, 8'h01);
    chk("R4 other address ignored", lane_en, 4'b1111);
    snoop(20'h00601, 8'h00);
    chk("R4 power untouched by other address", lane_en, 4'b1111);
  endtask

  task automatic t_modes();
    mode_sel = 2'd0; settle();
    chk("R2 mode 0", lane_en, 4'b0000);
    mode_sel = 2'd1; settle();
    chk("R2 mode 1", lane_en, 4'b0000);
    mode_sel = 2'd3; settle();
    snoop(20'h00600, 8'h01);
    snoop(20'h00101, 8'h04);
    chk("R3 mode 3 snoop four", lane_en, 4'b0011);
    snoop_off = 1'b1; lane_sw_dis = 4'b0000; settle();
    chk("R3 mode 3 register path", lane_en, 4'b0011);
    snoop_off = 1'b0; mode_sel = 2'd2; settle();
    chk("R8 mode 3 to 2 keeps capture", lane_en, 4'b1111);
  endtask

  task automatic t_regpath();
    snoop_off = 1'b1; lane_sw_dis = 4'b0101; settle();
    chk("R7 disable bits 0101", lane_en, 4'b1010);
    lane_sw_dis = 4'b1000; settle();
    chk("R7 disable bit 3", lane_en, 4'b0111);
    snoop_off = 1'b0; lane_sw_dis = 4'b1111; settle();
    chk("R7 disable bits ignored in snoop", lane_en, 4'b1111);
    lane_sw_dis = 4'b0000; settle();
  endtask

  task automatic t_clear();
    mode_sel = 2'd0; settle();
    mode_sel = 2'd2; settle();
    chk("R8 fall clears capture", lane_en, 4'b0000);
    snoop(20'h00101, 8'h02);
    @(negedge clk);
    mode_sel = 2'd0; snp_valid = 1'b1; snp_addr = 20'h00600; snp_data = 8'h01;
    @(negedge clk);
    snp_valid = 1'b0; mode_sel = 2'd2; settle();
    chk("R8 clear wins over strobe", lane_en, 4'b0000);
    snoop(20'h00600, 8'h01);
    chk("R8 count also cleared", lane_en, 4'b1111);
  endtask

  task automatic t_sbu();
    mode_sel = 2'd2; flip = 1'b0;
    aux_ovr = 2'd1; settle();
    chk("R9 override straight", {2'b00, sbu_ctl}, 4'b0001);
    aux_ovr = 2'd2; settle();
    chk("R9 override crossed", {2'b00, sbu_ctl}, 4'b0010);
    aux_ovr = 2'd3; settle();
    chk("R9 override open", {2'b00, sbu_ctl}, 4'b0000);
    mode_sel = 2'd0; aux_ovr = 2'd1; settle();
    chk("R9 override ignores mode", {2'b00, sbu_ctl}, 4'b0001);
    aux_ovr = 2'd0; flip = 1'b1; settle();
    chk("R10 mode 0 open", {2'b00, sbu_ctl}, 4'b0000);
    mode_sel = 2'd1; settle();
    chk("R10 mode 1 open", {2'b00, sbu_ctl}, 4'b0000);
    mode_sel = 2'd2; settle();
    chk("R10 flipped crossed", {2'b00, sbu_ctl}, 4'b0010);
    mode_sel = 2'd3; flip = 1'b0; settle();
    chk("R10 mode 3 straight", {2'b00, sbu_ctl}, 4'b0001);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    t_reset();
    t_power();
    t_count();
    t_modes();
    t_regpath();
    t_clear();
    t_sbu();
    finish_run();
  end
endmodule